// File: doc/BRIEF.md
# General-purpose I/O block with pin interrupts

This block is an APB slave that owns up to four banks of general-purpose pins. Each bank has an output value register and a direction register, and software can read back the state of the bank's external pins after a two-flop synchroniser. Bank 0 is the only bank that can raise interrupts. Each of its pins has its own enable, mask, trigger type and polarity. An edge trigger is held in a latch until software clears it. A level trigger follows the synchronised pin.

All masked pin interrupts are ORed into one registered interrupt line. There is no native both-edges trigger. Software catches both edges by inverting a pin's polarity bit after each event. The register offsets are fixed, because driver code decodes them. Bank `p` has its output value at `0x00 + 12*p`, its direction at `0x04 + 12*p`, and its pin readback at `0x50 + 4*p`. The interrupt registers are:

- enable at `0x30`
- mask at `0x34`
- trigger type at `0x38`
- polarity at `0x3C`
- masked status at `0x40`
- unmasked (raw) status at `0x44`
- write-one-to-clear acknowledge at `0x4C`

Top module: `apb_pio_ctrl`

## Requirements
- R1: A synchronous active-high reset clears every output value, direction, enable, mask, type, polarity and edge latch. It drives `pin_out`, `pin_oe`, `irq` and `prdata` to zero.
- R2: A write to `0x00+12*p` or `0x04+12*p` sets bank p's output value or direction. Bank p occupies bits `[PORT_W*p +: PORT_W]` of `pin_out` and `pin_oe`, and a 1 in the direction register means output. Both registers read back at the same offsets.
- R3: A read at `0x50+4*p` returns bank p's pins after the two-flop synchroniser. Writes to these offsets are ignored. Reads of unmapped offsets return zero.
- R4: With type bit 1 (at `0x38`) a pin is level-triggered. Polarity bit 1 (at `0x3C`) makes high active and 0 makes low active. Its status bit clears by itself when the pin becomes inactive.
- R5: With type bit 0 a pin is edge-triggered. Polarity 1 latches a rising edge and polarity 0 latches a falling edge. The latched bit stays set after the pin returns.
- R6: Writing 1 to a bit at `0x4C` clears that pin's edge latch, and writing 0 leaves it unchanged. The acknowledge register has no effect on level triggers and reads as zero.
- R7: A pin whose enable bit (at `0x30`) is 0 never sets its raw status, and clearing the enable bit drops a pending edge latch.
- R8: A mask bit of 1 (at `0x34`) removes the pin from the status at `0x40` and from `irq`, but the pin stays visible in the raw status at `0x44`.
- R9: `irq` is the OR of all masked status bits, registered one cycle later.
- R10: Pins of banks 1 to 3 never affect interrupt status.
- R11: If an edge and an acknowledge of the same pin land in the same clock cycle, the pin stays latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 7 | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data, valid in the access phase |
| pin_in | input | NUM_PORTS*PORT_W | External pin levels, asynchronous |
| pin_out | output | NUM_PORTS*PORT_W | Output value per pin |
| pin_oe | output | NUM_PORTS*PORT_W | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The pin patterns set bank 0 pins high and low in an order that separates the trigger kinds.

- **Level triggers.** Two pins have opposite polarity. One becomes active and the other inactive on the same pattern, which shows that polarity selects the active level and that the status bit drops without an acknowledge.
- **Edge triggers.** Two pins see a rising and then a falling transition. One set of patterns catches a latch that fires on the wrong edge, and the readback after the pins return catches a latch that does not hold.
- **Other banks.** Patterns on banks 1 to 3 use distinct byte values, so crossed readback lanes show up. Toggling all of them together shows whether they leak into the interrupt status.
- **Same-cycle edge and acknowledge.** A directed test aligns a rising edge with its acknowledge in the same cycle. A design where the clear wins loses that event.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned ADDR_W      = 7;
  localparam int unsigned MAX_PORTS   = 4;
  localparam int unsigned PORT_STRIDE = 12;
  localparam int unsigned PINS_STRIDE = 4;

  localparam logic [ADDR_W-1:0] OFS_VAL0  = 7'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR0  = 7'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 7'h30;
  localparam logic [ADDR_W-1:0] OFS_IMASK = 7'h34;
  localparam logic [ADDR_W-1:0] OFS_ITYPE = 7'h38;
  localparam logic [ADDR_W-1:0] OFS_IPOL  = 7'h3C;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 7'h40;
  localparam logic [ADDR_W-1:0] OFS_IRAW  = 7'h44;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 7'h4C;
  localparam logic [ADDR_W-1:0] OFS_PINS0 = 7'h50;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VAL,
    SEL_DIR,
    SEL_PINS,
    SEL_IEN,
    SEL_IMASK,
    SEL_ITYPE,
    SEL_IPOL,
    SEL_ISTAT,
    SEL_IRAW,
    SEL_ACK
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e    sel;
    logic [1:0]  bank;
  } reg_dec_t;

  function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_dec_t d;
    d.sel  = SEL_NONE;
    d.bank = '0;
    for (int p = 0; p < MAX_PORTS; p++) begin
      if (a == OFS_VAL0 + ADDR_W'(p * PORT_STRIDE)) begin
        d.sel  = SEL_VAL;
        d.bank = 2'(p);
      end
      if (a == OFS_DIR0 + ADDR_W'(p * PORT_STRIDE)) begin
        d.sel  = SEL_DIR;
        d.bank = 2'(p);
      end
      if (a == OFS_PINS0 + ADDR_W'(p * PINS_STRIDE)) begin
        d.sel  = SEL_PINS;
        d.bank = 2'(p);
      end
    end
    case (a)
      OFS_IEN:   d.sel = SEL_IEN;
      OFS_IMASK: d.sel = SEL_IMASK;
      OFS_ITYPE: d.sel = SEL_ITYPE;
      OFS_IPOL:  d.sel = SEL_IPOL;
      OFS_ISTAT: d.sel = SEL_ISTAT;
      OFS_IRAW:  d.sel = SEL_IRAW;
      OFS_ACK:   d.sel = SEL_ACK;
      default:   ;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/pio_bank_regs.sv
module pio_bank_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         val_we,
  input  logic         dir_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] val_q,
  output logic [W-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q <= '0;
      dir_q <= '0;
    end else begin
      if (val_we) val_q <= wdata;
      if (dir_we) dir_q <= wdata;
    end
  end

endmodule

// File: rtl/pio_irq_unit.sv
module pio_irq_unit #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_s,
  input  logic         en_we,
  input  logic         mask_we,
  input  logic         type_we,
  input  logic         pol_we,
  input  logic         ack_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] en_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] raw,
  output logic [W-1:0] status
);

  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q;
  logic [W-1:0] rise, fall, hit, clr, latch_d, lvl_act;

  always_comb begin
    rise    = pin_s & ~prev_q;
    fall    = ~pin_s & prev_q;
    hit     = (pol_q & rise) | (~pol_q & fall);
    clr     = ack_we ? wdata : '0;
    // a fresh edge wins over an acknowledge of the same cycle
    latch_d = en_q & ~type_q & (hit | (latch_q & ~clr));
    lvl_act = ~(pin_s ^ pol_q);
    raw     = (en_q & type_q & lvl_act) | latch_q;
    status  = raw & ~mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      latch_q <= '0;
      en_q    <= '0;
      mask_q  <= '0;
      type_q  <= '0;
      pol_q   <= '0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= latch_d;
      if (en_we)   en_q   <= wdata;
      if (mask_we) mask_q <= wdata;
      if (type_we) type_q <= wdata;
      if (pol_we)  pol_q  <= wdata;
    end
  end

  // R5: an armed latch with no clear in flight stays set
  a_r5_latch_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & $past(latch_q & en_q & ~type_q & ~clr)) ==
              $past(latch_q & en_q & ~type_q & ~clr)))
    else $error("a_r5_latch_holds");

  // R6: acknowledged bits without a coincident edge are cleared
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ack_we |=> ((latch_q & $past(wdata & ~hit)) == '0))
    else $error("a_r6_ack_clears");

  // R7: a disabled pin holds no latched event in the next cycle
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((latch_q & $past(~en_q)) == '0))
    else $error("a_r7_disabled_quiet");

endmodule

// File: rtl/apb_pio_ctrl.sv
module apb_pio_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W    = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        psel,
  input  logic                        penable,
  input  logic                        pwrite,
  input  logic [ADDR_W-1:0]           paddr,
  input  logic [DATA_W-1:0]           pwdata,
  output logic [DATA_W-1:0]           prdata,
  input  logic [NUM_PORTS*PORT_W-1:0] pin_in,
  output logic [NUM_PORTS*PORT_W-1:0] pin_out,
  output logic [NUM_PORTS*PORT_W-1:0] pin_oe,
  output logic                        irq
);

  localparam int unsigned PIN_W = NUM_PORTS * PORT_W;

  logic              wr_fire, rd_setup, bank_ok;
  reg_dec_t          dec;
  logic [PIN_W-1:0]  pin_s;
  logic [PORT_W-1:0] wdata;
  logic [PORT_W-1:0] val_arr  [NUM_PORTS];
  logic [PORT_W-1:0] dir_arr  [NUM_PORTS];
  logic [PORT_W-1:0] pins_arr [NUM_PORTS];
  logic [PORT_W-1:0] en_q, mask_q, type_q, pol_q, raw, status;
  logic [DATA_W-1:0] rd_word;

  assign wr_fire  = psel & penable & pwrite;
  assign rd_setup = psel & ~penable & ~pwrite;
  assign dec      = decode_addr(paddr);
  assign bank_ok  = (int'(dec.bank) < NUM_PORTS);
  assign wdata    = pwdata[PORT_W-1:0];

  pio_sync #(.W(PIN_W)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_bank
    logic val_we, dir_we;
    assign val_we = wr_fire && (dec.sel == SEL_VAL) && (dec.bank == 2'(p));
    assign dir_we = wr_fire && (dec.sel == SEL_DIR) && (dec.bank == 2'(p));

    pio_bank_regs #(.W(PORT_W)) u_regs (
      .clk    (clk),
      .rst    (rst),
      .val_we (val_we),
      .dir_we (dir_we),
      .wdata  (wdata),
      .val_q  (val_arr[p]),
      .dir_q  (dir_arr[p])
    );

    assign pins_arr[p]                 = pin_s[p*PORT_W +: PORT_W];
    assign pin_out[p*PORT_W +: PORT_W] = val_arr[p];
    assign pin_oe[p*PORT_W +: PORT_W]  = dir_arr[p];
  end

  pio_irq_unit #(.W(PORT_W)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .pin_s   (pins_arr[0]),
    .en_we   (wr_fire && dec.sel == SEL_IEN),
    .mask_we (wr_fire && dec.sel == SEL_IMASK),
    .type_we (wr_fire && dec.sel == SEL_ITYPE),
    .pol_we  (wr_fire && dec.sel == SEL_IPOL),
    .ack_we  (wr_fire && dec.sel == SEL_ACK),
    .wdata   (wdata),
    .en_q    (en_q),
    .mask_q  (mask_q),
    .type_q  (type_q),
    .pol_q   (pol_q),
    .raw     (raw),
    .status  (status)
  );

  always_comb begin
    rd_word = '0;
    case (dec.sel)
      SEL_VAL:   if (bank_ok) rd_word[PORT_W-1:0] = val_arr[dec.bank];
      SEL_DIR:   if (bank_ok) rd_word[PORT_W-1:0] = dir_arr[dec.bank];
      SEL_PINS:  if (bank_ok) rd_word[PORT_W-1:0] = pins_arr[dec.bank];
      SEL_IEN:   rd_word[PORT_W-1:0] = en_q;
      SEL_IMASK: rd_word[PORT_W-1:0] = mask_q;
      SEL_ITYPE: rd_word[PORT_W-1:0] = type_q;
      SEL_IPOL:  rd_word[PORT_W-1:0] = pol_q;
      SEL_ISTAT: rd_word[PORT_W-1:0] = status;
      SEL_IRAW:  rd_word[PORT_W-1:0] = raw;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prdata <= '0;
      irq    <= 1'b0;
    end else begin
      if (rd_setup) prdata <= rd_word;
      irq <= |status;
    end
  end

  // R1: the cycle after reset all pin drivers and the interrupt are quiet
  a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq == 1'b0 && pin_oe == '0 && pin_out == '0))
    else $error("a_r1_reset_quiet");

  // R9: the interrupt line trails the masked status by one register
  a_r9_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|status)))
    else $error("a_r9_irq_tracks");

  // R8: the line only rises for a pin that was raw-active and unmasked
  a_r8_mask_hides: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|(raw & ~mask_q)))
    else $error("a_r8_mask_hides");

endmodule

// File: tb/tb_apb_pio_ctrl.sv
module tb_apb_pio_ctrl;

  localparam int NP = 4;
  localparam int PW = 8;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_PIN = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 60;

  // {requirement, op, address, data or expected}
  localparam logic [44:0] STIM [NV] = '{
    {4'd2,  OP_WR,  7'h00, 32'h0000_00A5}, // R2
    {4'd2,  OP_RD,  7'h00, 32'h0000_00A5}, // R2
    {4'd2,  OP_WR,  7'h10, 32'h0000_003C}, // R2 bank 1 direction
    {4'd2,  OP_RD,  7'h10, 32'h0000_003C}, // R2
    {4'd2,  OP_WR,  7'h24, 32'h0000_0081}, // R2 bank 3 value
    {4'd2,  OP_RD,  7'h24, 32'h0000_0081}, // R2
    {4'd2,  OP_RD,  7'h0C, 32'h0000_0000}, // R2 bank 1 value untouched
    {4'd3,  OP_PIN, 7'h00, 32'h1234_5600}, // R3
    {4'd3,  OP_RD,  7'h50, 32'h0000_0000}, // R3
    {4'd3,  OP_RD,  7'h54, 32'h0000_0056}, // R3
    {4'd3,  OP_RD,  7'h58, 32'h0000_0034}, // R3
    {4'd3,  OP_RD,  7'h5C, 32'h0000_0012}, // R3
    {4'd3,  OP_WR,  7'h54, 32'h0000_00FF}, // R3 read-only write
    {4'd3,  OP_RD,  7'h54, 32'h0000_0056}, // R3
    {4'd3,  OP_RD,  7'h08, 32'h0000_0000}, // R3 unmapped
    {4'd4,  OP_WR,  7'h38, 32'h0000_0003}, // R4 bits 0,1 level
    {4'd4,  OP_WR,  7'h3C, 32'h0000_0001}, // R4 bit0 high, bit1 low
    {4'd4,  OP_WR,  7'h30, 32'h0000_0003}, // R4
    {4'd4,  OP_RD,  7'h40, 32'h0000_0002}, // R4 low-active pin is low
    {4'd9,  OP_IRQ, 7'h00, 32'h0000_0001}, // R9
    {4'd4,  OP_PIN, 7'h00, 32'h1234_5601}, // R4
    {4'd4,  OP_RD,  7'h40, 32'h0000_0003}, // R4
    {4'd6,  OP_WR,  7'h4C, 32'h0000_0003}, // R6 ack on level pins
    {4'd6,  OP_RD,  7'h40, 32'h0000_0003}, // R6
    {4'd4,  OP_PIN, 7'h00, 32'h1234_5602}, // R4
    {4'd4,  OP_RD,  7'h40, 32'h0000_0000}, // R4 self-clearing
    {4'd9,  OP_IRQ, 7'h00, 32'h0000_0000}, // R9
    {4'd5,  OP_WR,  7'h3C, 32'h0000_0005}, // R5 bit2 rising, bit3 falling
    {4'd5,  OP_WR,  7'h30, 32'h0000_000F}, // R5
    {4'd5,  OP_PIN, 7'h00, 32'h1234_560E}, // R5 bits 2,3 rise
    {4'd5,  OP_RD,  7'h40, 32'h0000_0004}, // R5
    {4'd5,  OP_PIN, 7'h00, 32'h1234_5602}, // R5 bits 2,3 fall
    {4'd5,  OP_RD,  7'h40, 32'h0000_000C}, // R5 bit2 held
    {4'd9,  OP_IRQ, 7'h00, 32'h0000_0001}, // R9
    {4'd6,  OP_WR,  7'h4C, 32'h0000_0004}, // R6
    {4'd6,  OP_RD,  7'h40, 32'h0000_0008}, // R6
    {4'd6,  OP_WR,  7'h4C, 32'h0000_0000}, // R6 zero write
    {4'd6,  OP_RD,  7'h40, 32'h0000_0008}, // R6
    {4'd6,  OP_RD,  7'h4C, 32'h0000_0000}, // R6 reads zero
    {4'd8,  OP_WR,  7'h34, 32'h0000_0008}, // R8
    {4'd8,  OP_RD,  7'h40, 32'h0000_0000}, // R8
    {4'd8,  OP_RD,  7'h44, 32'h0000_0008}, // R8 raw still set
    {4'd8,  OP_IRQ, 7'h00, 32'h0000_0000}, // R8
    {4'd8,  OP_WR,  7'h34, 32'h0000_0000}, // R8
    {4'd8,  OP_RD,  7'h40, 32'h0000_0008}, // R8
    {4'd9,  OP_IRQ, 7'h00, 32'h0000_0001}, // R9
    {4'd7,  OP_WR,  7'h30, 32'h0000_0007}, // R7 disable bit3
    {4'd7,  OP_RD,  7'h44, 32'h0000_0000}, // R7
    {4'd7,  OP_WR,  7'h30, 32'h0000_000F}, // R7
    {4'd7,  OP_RD,  7'h44, 32'h0000_0000}, // R7 stays dropped
    {4'd7,  OP_WR,  7'h30, 32'h0000_0003}, // R7 disable edge pins
    {4'd7,  OP_PIN, 7'h00, 32'h1234_5606}, // R7 bit2 rises
    {4'd7,  OP_RD,  7'h44, 32'h0000_0000}, // R7
    {4'd7,  OP_WR,  7'h30, 32'h0000_000F}, // R7
    {4'd7,  OP_RD,  7'h44, 32'h0000_0000}, // R7
    {4'd4,  OP_RD,  7'h38, 32'h0000_0003}, // R4 type readback
    {4'd10, OP_PIN, 7'h00, 32'hFFFF_FF06}, // R10 banks 1..3 high
    {4'd10, OP_RD,  7'h40, 32'h0000_0000}, // R10
    {4'd10, OP_PIN, 7'h00, 32'h0000_0006}, // R10
    {4'd10, OP_RD,  7'h44, 32'h0000_0000}  // R10
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [6:0]        paddr = '0;
  logic [31:0]       pwdata = '0;
  logic [31:0]       prdata;
  logic [NP*PW-1:0]  pin_in = '0;
  logic [NP*PW-1:0]  pin_out, pin_oe;
  logic              irq;
  int                n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  apb_pio_ctrl #(.NUM_PORTS(NP), .PORT_W(PW), .DATA_W(32)) dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apb_wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (all requirements): got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    // R1: reset state at the ports
    check("R1 prdata", prdata, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rst = 1'b0;
    apb_rd(7'h30, rd); check("R1 enable", rd, 32'h0);
    apb_rd(7'h3C, rd); check("R1 polarity", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  rq;
      logic [1:0]  op;
      logic [6:0]  ad;
      logic [31:0] dv;
      string       tag;
      {rq, op, ad, dv} = STIM[i];
      tag = $sformatf("R%0d entry %0d", rq, i);
      case (op)
        OP_WR:   apb_wr(ad, dv);
        OP_RD:   begin apb_rd(ad, rd); check(tag, rd, dv); end
        OP_PIN:  set_pins(dv);
        default: begin
          repeat (2) @(negedge clk);
          check(tag, {31'h0, irq}, dv);
        end
      endcase
    end

    // R2: lanes on the pin buses
    check("R2 pin_out lanes", pin_out, 32'h8100_00A5);
    check("R2 pin_oe lanes", pin_oe, 32'h0000_3C00);

    // R11: rising edge on bit2 lands in the ack cycle
    set_pins(32'h0000_0002);
    apb_wr(7'h4C, 32'h0000_0004);
    apb_rd(7'h44, rd); check("R11 pre-clear", rd, 32'h0);
    set_pins(32'h0000_0006);
    apb_rd(7'h44, rd); check("R11 first edge", rd, 32'h4);
    set_pins(32'h0000_0002);
    @(negedge clk);
    pin_in = 32'h0000_0006;
    @(posedge clk);
    apb_wr(7'h4C, 32'h0000_0004);
    apb_rd(7'h44, rd); check("R11 coincident edge kept", rd, 32'h4);
    apb_wr(7'h4C, 32'h0000_0004);
    apb_rd(7'h44, rd); check("R11 later ack clears", rd, 32'h0);

    // R1: reset in mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 mid pin_out", pin_out, 32'h0);
    rst = 1'b0;
    apb_rd(7'h24, rd); check("R1 mid value", rd, 32'h0);
    apb_rd(7'h3C, rd); check("R1 mid polarity", rd, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule